// File: doc/BRIEF.md
# Descriptor Table Register Loader

This block fills one of two system segment registers from a selector: either the register that points at the local descriptor table or the task register. A load request carries a 16-bit selector and a target choice. The block walks the eight bytes of the matching entry in the global descriptor table over a byte-wide read port, one request at a time. It then rebuilds the scattered base and limit fields, scales the limit when the granularity flag is set, and writes selector, base, limit and access byte into the chosen register in one cycle.

A privilege gate runs before any memory traffic starts. With protection enabled, a request made at a nonzero privilege level or in virtual-8086 mode is refused and answered with a one-cycle fault pulse. A memory abort during the walk cancels the load and leaves both registers as they were. A separate combinational store path returns the selector currently held by either register.

Top module: `dtr_loader`

## Requirements
- R1: After reset all eight register outputs and the store output read zero, and `busy`, `mem_req`, `done` and `fault` are low.
- R2: If `pe` is 1 and either `cpl` is nonzero or `v86` is 1, a `start` produces exactly one cycle of `fault` high. It issues no memory request and changes no register.
- R3: With `pe` at 0, a load proceeds whatever the values of `cpl` and `v86`.
- R4: The read addresses are `gdt_base + {sel[15:3],3'b000} + k` for k = 0 to 7, in ascending order, one byte per acknowledged cycle. Selector bits 2:0 (table indicator and requested privilege) do not change the address.
- R5: The stored limit before scaling is `{byte6[3:0], byte1, byte0}`, zero-extended to 32 bits. The upper nibble of byte 6 does not enter the limit.
- R6: The stored base is `{byte7, byte4, byte3, byte2}`.
- R7: The stored access field is byte 5.
- R8: When bit 7 of byte 6 is 1, the stored limit is the 20-bit limit shifted left by 12 with bits 11:0 set to ones.
- R9: Selector, base, limit and access of the target change together in the same cycle. `done` is high for one cycle after that cycle, and the register keeps its old contents until then.
- R10: `mem_abort` during any read cancels the load. No `done` follows and both registers keep their previous contents.
- R11: `store_sel` shows the LDT-pointer selector when `store_tgt` is 0 and the task-register selector when it is 1.
- R12: `tgt` = 0 loads the LDT-pointer register and `tgt` = 1 loads the task register. The other register is left unchanged.
- R13: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request, sampled while idle |
| tgt | input | 1 | 0 = LDT-pointer register, 1 = task register |
| sel_in | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| v86 | input | 1 | Virtual-8086 mode active |
| pe | input | 1 | Protection enabled |
| gdt_base | input | 32 | Global descriptor table base address |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Read completed this cycle |
| mem_abort | input | 1 | Read aborted; cancels the load |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse after a commit |
| fault | output | 1 | One-cycle protection fault pulse |
| ldt_sel | output | 16 | LDT-pointer selector |
| ldt_base | output | 32 | LDT-pointer base |
| ldt_limit | output | 32 | LDT-pointer limit |
| ldt_access | output | 8 | LDT-pointer access byte |
| tr_sel | output | 16 | Task register selector |
| tr_base | output | 32 | Task register base |
| tr_limit | output | 32 | Task register limit |
| tr_access | output | 8 | Task register access byte |
| store_tgt | input | 1 | Store path target choice |
| store_sel | output | 16 | Selector returned by the store path |

## Verification
The hardest case to reach from the ports is an abort that lands partway through the byte walk, after some descriptor bytes have already been captured. The bench reaches it with a memory model that counts acknowledged transfers and raises `mem_abort` for one cycle after the third byte. It then compares both registers against their earlier contents. A second hard case is a `start` arriving in the middle of a walk. The bench issues a second request with a different selector and target while `busy` is high, and then confirms that only the first load committed. Slow-acknowledge mode inserts gaps between transfers so that the one-request-at-a-time ordering is exercised under stalls.

// File: rtl/dtr_loader.sv
module dtr_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tgt,
  input  logic [15:0] sel_in,
  input  logic [1:0]  cpl,
  input  logic        v86,
  input  logic        pe,
  input  logic [31:0] gdt_base,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_abort,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [15:0] ldt_sel,
  output logic [31:0] ldt_base,
  output logic [31:0] ldt_limit,
  output logic [7:0]  ldt_access,
  output logic [15:0] tr_sel,
  output logic [31:0] tr_base,
  output logic [31:0] tr_limit,
  output logic [7:0]  tr_access,
  input  logic        store_tgt,
  output logic [15:0] store_sel
);

  localparam int NBYTES = 8;
  localparam int IW     = $clog2(NBYTES);
  localparam int NREG   = 2;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_COMMIT} state_t;

  state_t              st;
  logic [IW-1:0]       idx;
  logic                tgt_q;
  logic [15:0]         sel_q;
  logic [31:0]         walk_base;
  logic [NBYTES*8-1:0] desc_q;

  logic [15:0] rsel [NREG];
  logic [31:0] rbase[NREG];
  logic [31:0] rlim [NREG];
  logic [7:0]  racc [NREG];

  logic [31:0] raw_lim, new_lim, new_base;
  logic        gbit, refuse;

  assign refuse   = pe && ((cpl != 2'd0) || v86);
  assign mem_req  = (st == S_READ);
  assign mem_addr = walk_base + {{(32-IW){1'b0}}, idx};
  assign busy     = (st != S_IDLE);

  assign gbit     = desc_q[55];
  assign raw_lim  = {12'h000, desc_q[51:48], desc_q[15:0]};
  assign new_lim  = gbit ? {raw_lim[19:0], 12'hFFF} : raw_lim;
  assign new_base = {desc_q[63:56], desc_q[39:32], desc_q[31:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      tgt_q     <= 1'b0;
      sel_q     <= '0;
      walk_base <= '0;
      desc_q    <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        rsel[i]  <= '0;
        rbase[i] <= '0;
        rlim[i]  <= '0;
        racc[i]  <= '0;
      end
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (refuse) fault <= 1'b1;
          else begin
            st        <= S_READ;
            idx       <= '0;
            tgt_q     <= tgt;
            sel_q     <= sel_in;
            walk_base <= gdt_base + {16'h0000, sel_in[15:3], 3'b000};
          end
        end
        S_READ: begin
          if (mem_abort) st <= S_IDLE;
          else if (mem_ack) begin
            desc_q[{idx, 3'b000} +: 8] <= mem_rdata;
            if (idx == IW'(NBYTES - 1)) st <= S_COMMIT;
            else idx <= idx + 1'b1;
          end
        end
        S_COMMIT: begin
          rsel[tgt_q]  <= sel_q;
          rbase[tgt_q] <= new_base;
          rlim[tgt_q]  <= new_lim;
          racc[tgt_q]  <= desc_q[47:40];
          done         <= 1'b1;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ldt_sel    = rsel[0];
  assign ldt_base   = rbase[0];
  assign ldt_limit  = rlim[0];
  assign ldt_access = racc[0];
  assign tr_sel     = rsel[1];
  assign tr_base    = rbase[1];
  assign tr_limit   = rlim[1];
  assign tr_access  = racc[1];
  assign store_sel  = store_tgt ? rsel[1] : rsel[0];

  assert_fault_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_req && !busy && !done));

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req && mem_ack && !mem_abort)) |-> (mem_addr == $past(mem_addr) + 32'd1));

  assert_ldt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_COMMIT) |=> ($stable(ldt_sel) && $stable(ldt_base) && $stable(ldt_limit) && $stable(ldt_access)));

  assert_tr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_COMMIT) |=> ($stable(tr_sel) && $stable(tr_base) && $stable(tr_limit) && $stable(tr_access)));

  assert_abort_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_abort) |=> (!mem_req && !done && !busy));

  assert_gran_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && gbit) |-> (store_tgt ? 1'b1 : 1'b1) && (rlim[tgt_q][11:0] == 12'hFFF));

endmodule

// File: tb/dtr_loader_test.sv
module dtr_loader_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, tgt, v86, pe, mem_abort, store_tgt, slow, ack_gap;
  logic [15:0] sel_in;
  logic [1:0]  cpl;
  logic [31:0] gdt_base;
  logic        mem_req, mem_ack, busy, done, fault;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] ldt_sel, tr_sel, store_sel;
  logic [31:0] ldt_base, ldt_limit, tr_base, tr_limit;
  logic [7:0]  ldt_access, tr_access;

  logic [7:0]  mem [256];
  logic [31:0] alog [16];
  int nlog, errors, checks, cyc;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ack   = mem_req && !ack_gap;

  dtr_loader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt(tgt), .sel_in(sel_in),
    .cpl(cpl), .v86(v86), .pe(pe), .gdt_base(gdt_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_abort(mem_abort), .busy(busy), .done(done),
    .fault(fault), .ldt_sel(ldt_sel), .ldt_base(ldt_base),
    .ldt_limit(ldt_limit), .ldt_access(ldt_access), .tr_sel(tr_sel),
    .tr_base(tr_base), .tr_limit(tr_limit), .tr_access(tr_access),
    .store_tgt(store_tgt), .store_sel(store_sel)
  );

  always @(negedge clk) ack_gap <= slow ? ~ack_gap : 1'b0;

  always @(negedge clk)
    if (mem_req && mem_ack && !mem_abort && nlog < 16) begin
      alog[nlog] = mem_addr;
      nlog = nlog + 1;
    end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R9 watchdog expired: actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // {tgt, sel, descriptor bytes 7..0}
  localparam int NV = 6;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 16'h0008, 64'hBC05829A56781234},
    {1'b1, 16'h003F, 64'h008F890012340067},
    {1'b0, 16'h1230, 64'hFF4FF2FFFFFFFFFF},
    {1'b1, 16'h0010, 64'h0080000000000000},
    {1'b0, 16'hFFF8, 64'h12C3E145670A0B0C},
    {1'b1, 16'h0048, 64'hA57F890123456789}
  };

  function automatic logic [31:0] exp_lim(input logic [63:0] d);
    logic [31:0] r;
    r = {12'h000, d[51:48], d[15:0]};
    return d[55] ? {r[19:0], 12'hFFF} : r;
  endfunction

  function automatic logic [31:0] exp_base(input logic [63:0] d);
    return {d[63:56], d[39:32], d[31:16]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic place(input logic [31:0] gb, input logic [15:0] s, input logic [63:0] d);
    logic [31:0] a;
    a = gb + {16'h0, s[15:3], 3'b000};
    for (int k = 0; k < 8; k++) mem[8'(a + k)] = d[k*8 +: 8];
  endtask

  task automatic pulse_start(input logic t, input logic [15:0] s, input logic [31:0] gb);
    @(negedge clk);
    tgt = t; sel_in = s; gdt_base = gb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic snap(output logic [87:0] l, output logic [87:0] t);
    l = {ldt_sel, ldt_base, ldt_limit, ldt_access};
    t = {tr_sel, tr_base, tr_limit, tr_access};
  endtask

  task automatic run_load(input string tag, input logic t, input logic [15:0] s,
                          input logic [63:0] d, input logic [31:0] gb);
    logic [87:0] ol, ot, nl, nt, other_old, other_new;
    int early, w;
    place(gb, s, d);
    snap(ol, ot);
    nlog = 0;
    early = 0;
    pulse_start(t, s, gb);
    w = 0;
    while (!done && w < 60) begin
      snap(nl, nt);
      if ((t ? nt : nl) !== (t ? ot : ol)) early = early + 1;
      @(negedge clk);
      w = w + 1;
    end
    chk({tag, " R9 done seen"}, 32'(done), 32'd1);
    chk({tag, " R9 no early change"}, early, 0);
    chk({tag, " R4 count"}, nlog, 8);
    for (int k = 0; k < 8; k++)
      chk({tag, " R4 addr"}, alog[k], gb + {16'h0, s[15:3], 3'b000} + k);
    if (!t) begin
      chk({tag, " R12 ldt sel"}, 32'(ldt_sel), 32'(s));
      chk({tag, " R6 base"}, ldt_base, exp_base(d));
      chk({tag, " R5 R8 limit"}, ldt_limit, exp_lim(d));
      chk({tag, " R7 access"}, 32'(ldt_access), 32'(d[47:40]));
    end else begin
      chk({tag, " R12 tr sel"}, 32'(tr_sel), 32'(s));
      chk({tag, " R6 base"}, tr_base, exp_base(d));
      chk({tag, " R5 R8 limit"}, tr_limit, exp_lim(d));
      chk({tag, " R7 access"}, 32'(tr_access), 32'(d[47:40]));
    end
    snap(nl, nt);
    other_old = t ? ol : ot;
    other_new = t ? nl : nt;
    chk({tag, " R12 other untouched"}, 32'(other_new != other_old), 32'd0);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic try_refused(input string tag, input logic [1:0] c, input logic v);
    logic [87:0] ol, ot, nl, nt;
    int fcnt;
    snap(ol, ot);
    pe = 1'b1; cpl = c; v86 = v;
    nlog = 0;
    fcnt = 0;
    pulse_start(1'b0, 16'h0018, 32'h0000_2000);
    if (fault) fcnt = fcnt + 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (fault) fcnt = fcnt + 1;
    end
    snap(nl, nt);
    chk({tag, " R2 fault pulses"}, fcnt, 1);
    chk({tag, " R2 no request"}, nlog, 0);
    chk({tag, " R2 regs kept"}, 32'({nl, nt} != {ol, ot}), 32'd0);
    cpl = 2'd0; v86 = 1'b0;
  endtask

  initial begin
    logic [87:0] ol, ot, nl, nt;
    int dcnt;
    errors = 0; checks = 0; cyc = 0; nlog = 0;
    rst_n = 1'b0; start = 1'b0; tgt = 1'b0; sel_in = '0; cpl = 2'd0; v86 = 1'b0;
    pe = 1'b1; gdt_base = '0; mem_abort = 1'b0; store_tgt = 1'b0; slow = 1'b0; ack_gap = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    snap(nl, nt);
    chk("R1 regs zero", 32'({nl, nt} != '0), 32'd0);
    chk("R1 store zero", 32'(store_sel), 32'd0);
    chk("R1 idle outputs", {28'd0, busy, mem_req, done, fault}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      slow = (i == 2);
      run_load($sformatf("vec%0d", i), VEC[i][80], VEC[i][79:64], VEC[i][63:0],
               32'h0010_0000 + 32'(i) * 32'h0000_1040);
    end
    slow = 1'b0;

    store_tgt = 1'b0; #1;
    chk("R11 store ldt", 32'(store_sel), 32'(VEC[4][79:64]));
    store_tgt = 1'b1; #1;
    chk("R11 store tr", 32'(store_sel), 32'(VEC[5][79:64]));

    try_refused("cpl3", 2'd3, 1'b0);
    try_refused("v86", 2'd0, 1'b1);
    try_refused("cpl1 v86", 2'd1, 1'b1);

    pe = 1'b0; cpl = 2'd3; v86 = 1'b1;
    run_load("R3 unprotected", 1'b0, 16'h0020, 64'h0312345678ABCDEF, 32'h0003_0000);
    pe = 1'b1; cpl = 2'd0; v86 = 1'b0;

    // R10: abort after three transfers
    snap(ol, ot);
    place(32'h0004_0000, 16'h0028, 64'h1111111111111111);
    nlog = 0;
    dcnt = 0;
    pulse_start(1'b1, 16'h0028, 32'h0004_0000);
    while (nlog < 3) @(negedge clk);
    mem_abort = 1'b1;
    @(negedge clk);
    mem_abort = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (done) dcnt = dcnt + 1;
      @(negedge clk);
    end
    snap(nl, nt);
    chk("R10 no done", dcnt, 0);
    chk("R10 idle", 32'(busy), 32'd0);
    chk("R10 regs kept", 32'({nl, nt} != {ol, ot}), 32'd0);

    // R13: second start while busy is ignored
    place(32'h0005_0000, 16'h0030, 64'h2222222222222222);
    place(32'h0005_0000, 16'h0038, 64'h3333333333333333);
    snap(ol, ot);
    pulse_start(1'b0, 16'h0030, 32'h0005_0000);
    @(negedge clk);
    tgt = 1'b1; sel_in = 16'h0038; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 30; k++) @(negedge clk);
    chk("R13 first load kept", 32'(ldt_sel), 32'h0030);
    chk("R13 first base", ldt_base, 32'h2222_2222);
    chk("R13 tr untouched", 32'(tr_sel), 32'(ot[87:72]));
    chk("R13 idle after", 32'(busy), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule